// File: doc/BRIEF.md
# Pipeline Stall Interlock Unit

This block decides, every cycle, whether the instruction sitting in the decode stage of an in-order five-stage pipeline may move on. The pipeline has no result forwarding. An operand is only usable once its producer has been written back. Writes land in the first half of the writeback cycle and reads happen in the second half, so a consumer may leave decode in the same cycle its producer is in writeback. Branches test their operands and compute their target in decode, so a branch waits there until the registers it compares are final.

Three execution paths of different length sit between decode and memory access:

- an integer path with one execute stage, which also carries loads and stores;
- a floating-point add path with four stages;
- a floating-point multiply path with seven stages.

For each path the unit keeps a shift chain recording the destination register of every instruction in flight. It compares the decode-stage register fields against these chains to find three kinds of conflict:

- read-after-write hazards;
- write-after-write ordering hazards;
- two writers reaching writeback in the same cycle.

When any conflict is found, `stall` holds the fetch and decode registers and `issue` stays low, so that a bubble with no write enable enters execute.

Top module: `ilk_stall_unit`

## Requirements
- R1: An instruction in decode stalls while either enabled source register equals the destination of an in-flight writer that has not yet reached its writeback cycle.
- R2: A source that matches a writer currently in its writeback cycle causes no stall, so that consumer leaves decode in that same cycle.
- R3: `branch_ready` is high exactly when a valid branch (`id_branch`=1) is in decode and neither of its enabled source registers is pending under R1.
- R4: An instruction that leaves decode reaches writeback a fixed number of cycles later: 3 on the integer path (`id_path`=0, and also the unused code 3), 6 on the float add path (`id_path`=1) and 9 on the float multiply path (`id_path`=2). A dependent instruction directly behind it therefore stalls for 2, 5 or 8 cycles.
- R5: An instruction with a destination stalls while an older in-flight writer of the same register would reach writeback in the same cycle as it or later.
- R6: An instruction with a destination stalls when any in-flight writer would reach writeback in the same cycle as it would. No two writers are ever in writeback together.
- R7: Register 0, a disabled source or destination field, and an invalid decode slot never produce a hazard.
- R8: `issue` equals `id_valid` and not `stall`. Only issued instructions with a live destination are recorded as in-flight writers.
- R9: Synchronous reset empties every in-flight record, so the first instruction after reset never stalls.
- R10: Several float operations can be in flight at once on both float paths without stalling independent instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_path | input | 2 | Execution path: 0 integer, 1 float add, 2 float multiply, 3 treated as integer |
| id_src1 | input | 5 | First source register |
| id_src1_en | input | 1 | First source is read |
| id_src2 | input | 5 | Second source register |
| id_src2_en | input | 1 | Second source is read |
| id_dst | input | 5 | Destination register |
| id_dst_en | input | 1 | Instruction writes a destination |
| id_branch | input | 1 | Instruction is a decode-resolved branch |
| stall | output | 1 | Hold fetch and decode, bubble into execute |
| issue | output | 1 | Instruction leaves decode this cycle |
| branch_ready | output | 1 | Branch operands are final, branch may resolve |

## Verification
The bench builds the unit with its default path depths of one, four and seven execute stages, which give writeback distances of 3, 6 and 9 cycles. With these depths every ordering collision is reachable. A later integer or add write can overtake an earlier multiply to the same register. A short write can also land exactly on the writeback cycle of a long one, and it takes only a few bubbles of spacing to make that happen. Directed streams measure the stall length on each path and step through branch waits, register 0 and a reset with work in flight. A long pseudo-random stream over eight registers then mixes all paths.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    parameter int REG_AW = 5;

    typedef enum logic [1:0] {
        PATH_INT  = 2'd0,
        PATH_FADD = 2'd1,
        PATH_FMUL = 2'd2,
        PATH_RSVD = 2'd3
    } path_e;

    // A register reference that only counts when it truly names a register.
    typedef struct packed {
        logic              live;
        logic [REG_AW-1:0] idx;
    } reg_ref_t;

    function automatic reg_ref_t make_ref(input logic vld, input logic en,
                                          input logic [REG_AW-1:0] idx);
        reg_ref_t r;
        r.live = vld && en && (idx != '0);
        r.idx  = idx;
        return r;
    endfunction

    // Cycles from leaving decode to writeback: execute stages, then memory, then writeback.
    function automatic int wb_lat(input int ex_stages);
        return ex_stages + 2;
    endfunction

endpackage

// File: rtl/ilk_wb_chain.sv
module ilk_wb_chain #(
    parameter int DEPTH = 3,
    parameter int AW    = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  logic [AW-1:0]             push_dst,
    output logic [DEPTH-1:0]          vld,
    output logic [DEPTH-1:0][AW-1:0]  dst
);
    // Entry k is the writer that left decode k+1 cycles ago; the last entry is in writeback.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            dst <= '0;
        end else begin
            vld <= {vld[DEPTH-2:0], push};
            dst <= {dst[DEPTH-2:0], push_dst};
        end
    end
endmodule

// File: rtl/ilk_path_scan.sv
module ilk_path_scan import ilk_pkg::*; #(
    parameter int DEPTH = 3,
    parameter int LW    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [DEPTH-1:0]              vld,
    input  logic [DEPTH-1:0][REG_AW-1:0]  dst,
    input  reg_ref_t                      src1,
    input  reg_ref_t                      src2,
    input  reg_ref_t                      wdst,
    input  logic [LW-1:0]                 new_lat,
    input  logic                          issue,
    input  logic                          br_ready,
    output logic                          raw_hit,
    output logic                          waw_hit,
    output logic                          port_hit
);
    always_comb begin
        raw_hit  = 1'b0;
        waw_hit  = 1'b0;
        port_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && (i < DEPTH-1)) begin
                if (src1.live && dst[i] == src1.idx) raw_hit = 1'b1;
                if (src2.live && dst[i] == src2.idx) raw_hit = 1'b1;
            end
            if (vld[i] && wdst.live) begin
                if ((dst[i] == wdst.idx) && ((DEPTH-1-i) >= int'(new_lat))) waw_hit = 1'b1;
                if ((DEPTH-1-i) == int'(new_lat)) port_hit = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH-1; g++) begin : g_raw_chk
        AST_NO_RAW_ISSUE: assert property (@(posedge clk) disable iff (rst)
            issue && vld[g] |-> !(src1.live && dst[g] == src1.idx) && !(src2.live && dst[g] == src2.idx)); // R1
        AST_BRANCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
            br_ready && vld[g] |-> !(src1.live && dst[g] == src1.idx) && !(src2.live && dst[g] == src2.idx)); // R3
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_waw_chk
        AST_NO_WAW_ISSUE: assert property (@(posedge clk) disable iff (rst)
            issue && wdst.live && vld[g] && dst[g] == wdst.idx |-> (DEPTH-1-g) < int'(new_lat)); // R5
    end
endmodule

// File: rtl/ilk_stall_unit.sv
module ilk_stall_unit import ilk_pkg::*; #(
    parameter int INT_EX  = 1,
    parameter int FADD_EX = 4,
    parameter int FMUL_EX = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid,
    input  logic [1:0]        id_path,
    input  logic [REG_AW-1:0] id_src1,
    input  logic              id_src1_en,
    input  logic [REG_AW-1:0] id_src2,
    input  logic              id_src2_en,
    input  logic [REG_AW-1:0] id_dst,
    input  logic              id_dst_en,
    input  logic              id_branch,
    output logic              stall,
    output logic              issue,
    output logic              branch_ready
);
    localparam int NPATH    = 3;
    localparam int LAT_INT  = wb_lat(INT_EX);
    localparam int LAT_FADD = wb_lat(FADD_EX);
    localparam int LAT_FMUL = wb_lat(FMUL_EX);
    localparam int LAT_MAX  = (LAT_FMUL > LAT_FADD) ? LAT_FMUL : LAT_FADD;
    localparam int LW       = $clog2(LAT_MAX + 1);

    reg_ref_t s1, s2, wd;
    path_e    path;
    logic [1:0]       sel;
    logic [LW-1:0]    new_lat;
    logic [NPATH-1:0] raw_v, waw_v, port_v, wb_vld, busy_v;

    assign s1   = make_ref(id_valid, id_src1_en, id_src1);
    assign s2   = make_ref(id_valid, id_src2_en, id_src2);
    assign wd   = make_ref(id_valid, id_dst_en, id_dst);
    assign path = path_e'(id_path);

    always_comb begin
        unique case (path)
            PATH_FADD: begin sel = 2'd1; new_lat = LW'(LAT_FADD); end
            PATH_FMUL: begin sel = 2'd2; new_lat = LW'(LAT_FMUL); end
            default:   begin sel = 2'd0; new_lat = LW'(LAT_INT);  end
        endcase
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        localparam int D = (p == 2) ? LAT_FMUL : ((p == 1) ? LAT_FADD : LAT_INT);
        logic [D-1:0]             vld;
        logic [D-1:0][REG_AW-1:0] dst;
        logic                     push;

        assign push = issue && wd.live && (sel == 2'(p));

        ilk_wb_chain #(.DEPTH(D), .AW(REG_AW)) u_chain (
            .clk(clk), .rst(rst), .push(push), .push_dst(wd.idx),
            .vld(vld), .dst(dst)
        );

        ilk_path_scan #(.DEPTH(D), .LW(LW)) u_scan (
            .clk(clk), .rst(rst), .vld(vld), .dst(dst),
            .src1(s1), .src2(s2), .wdst(wd), .new_lat(new_lat),
            .issue(issue), .br_ready(branch_ready),
            .raw_hit(raw_v[p]), .waw_hit(waw_v[p]), .port_hit(port_v[p])
        );

        assign wb_vld[p] = vld[D-1];
        assign busy_v[p] = |vld;
    end

    assign stall        = id_valid && ((|raw_v) || (|waw_v) || (|port_v));
    assign issue        = id_valid && !stall;
    assign branch_ready = id_valid && id_branch && !(|raw_v);

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        $countones(wb_vld) <= 1); // R6
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> busy_v == '0); // R9
    AST_NO_NAME_FREE: assert property (@(posedge clk) disable iff (rst)
        id_valid && !s1.live && !s2.live && !wd.live |-> !stall); // R7
    AST_BUBBLE_ON_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall |-> !issue && id_valid); // R8
endmodule

// File: tb/ilk_stall_unit_bench.sv
module ilk_stall_unit_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic id_valid = 1'b0, id_src1_en = 1'b0, id_src2_en = 1'b0, id_dst_en = 1'b0, id_branch = 1'b0;
    logic [1:0] id_path = 2'd0;
    logic [4:0] id_src1 = '0, id_src2 = '0, id_dst = '0;
    logic stall, issue, branch_ready;

    always #2 clk = ~clk;

    ilk_stall_unit u_ilk_stall_unit (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_path(id_path),
        .id_src1(id_src1), .id_src1_en(id_src1_en), .id_src2(id_src2), .id_src2_en(id_src2_en),
        .id_dst(id_dst), .id_dst_en(id_dst_en), .id_branch(id_branch),
        .stall(stall), .issue(issue), .branch_ready(branch_ready)
    );

    typedef struct { bit v; int path; int s1; bit s1e; int s2; bit s2e; int d; bit de; bit br; } ins_t;
    typedef struct { int d; int wb; } rec_t;

    rec_t q[$];
    ins_t prog[$];
    int   stall_cnt[$];
    int   now = 0;
    int   n_chk = 0, n_err = 0;

    function automatic ins_t mk(bit v, int path, int s1, bit s1e, int s2, bit s2e, int d, bit de, bit br);
        ins_t x;
        x.v = v; x.path = path; x.s1 = s1; x.s1e = s1e; x.s2 = s2; x.s2e = s2e;
        x.d = d; x.de = de; x.br = br;
        return x;
    endfunction

    function automatic int lat_of(int path);
        if (path == 1) return 6;
        if (path == 2) return 9;
        return 3;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference: each record holds the absolute cycle of its writeback.
    task automatic expect_of(input ins_t x, output bit st, output bit br, output string tag);
        bit raw = 0, waw = 0, prt = 0;
        bit l1 = x.v && x.s1e && x.s1 != 0;
        bit l2 = x.v && x.s2e && x.s2 != 0;
        bit ld = x.v && x.de && x.d != 0;
        int lat = lat_of(x.path);
        foreach (q[k]) begin
            int rem = q[k].wb - now;
            if (rem < 0) continue;
            if (rem > 0 && ((l1 && q[k].d == x.s1) || (l2 && q[k].d == x.s2))) raw = 1;
            if (ld && q[k].d == x.d && rem >= lat) waw = 1;
            if (ld && rem == lat) prt = 1;
        end
        st  = x.v && (raw || waw || prt);
        br  = x.v && x.br && !raw;
        tag = raw ? "R1" : (waw ? "R5" : (prt ? "R6" : "R2/R7"));
    endtask

    task automatic drive(input ins_t x);
        id_valid = x.v; id_path = 2'(x.path);
        id_src1 = 5'(x.s1); id_src1_en = x.s1e; id_src2 = 5'(x.s2); id_src2_en = x.s2e;
        id_dst = 5'(x.d); id_dst_en = x.de; id_branch = x.br;
    endtask

    task automatic run_prog(input int drain);
        int idx = 0;
        int extra = 0;
        stall_cnt.delete();
        foreach (prog[k]) stall_cnt.push_back(0);
        while (idx < prog.size() || extra < drain) begin
            ins_t x;
            bit es, eb, ei;
            string tg;
            if (idx < prog.size()) x = prog[idx];
            else begin x = mk(0, 0, 0, 0, 0, 0, 0, 0, 0); extra++; end
            @(negedge clk);
            drive(x);
            #1;
            expect_of(x, es, eb, tg);
            ei = x.v && !es;
            chk(stall == es, {"stall ", tg}, stall, es);
            chk(issue == ei, "issue R8", issue, ei);
            chk(branch_ready == eb, "branch_ready R3", branch_ready, eb);
            if (idx < prog.size() && x.v && es) stall_cnt[idx]++;
            @(posedge clk);
            if (ei && x.de && x.d != 0) begin
                rec_t r;
                r.d = x.d; r.wb = now + lat_of(x.path);
                q.push_back(r);
            end
            now++;
            while (q.size() > 0 && q[0].wb < now - 12) void'(q.pop_front());
            if (idx < prog.size() && (!x.v || ei)) idx++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        drive(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        bit [15:0] lfsr = 16'hACE1;
        do_reset();

        // R9: reset state, no stall for a reading instruction
        @(negedge clk);
        drive(mk(1, 0, 1, 1, 2, 1, 3, 1, 0));
        #1;
        chk(stall == 0, "reset stall R9", stall, 0);
        chk(issue == 1, "reset issue R9", issue, 1);
        drive(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
        do_reset();

        // R4 / R2 / R1: dependent stall length per path
        for (int p = 0; p < 3; p++) begin
            prog = '{mk(1, p, 0, 0, 0, 0, 1, 1, 0), mk(1, 0, 1, 1, 0, 0, 2, 1, 0)};
            run_prog(12);
            chk(stall_cnt[1] == lat_of(p) - 1, "dependent stall length R4", stall_cnt[1], lat_of(p) - 1);
        end

        // R5: short write to the same register behind a multiply
        prog = '{mk(1, 2, 0, 0, 0, 0, 3, 1, 0), mk(1, 0, 0, 0, 0, 0, 3, 1, 0)};
        run_prog(12);
        chk(stall_cnt[1] == 6, "write order stall R5", stall_cnt[1], 6);

        // R6: integer write landing on the multiply writeback cycle
        prog = '{mk(1, 2, 0, 0, 0, 0, 4, 1, 0)};
        for (int k = 0; k < 5; k++) prog.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
        prog.push_back(mk(1, 0, 0, 0, 0, 0, 7, 1, 0));
        run_prog(12);
        chk(stall_cnt[6] == 1, "port conflict int R6", stall_cnt[6], 1);

        // R6: float add landing on the multiply writeback cycle
        prog = '{mk(1, 2, 0, 0, 0, 0, 4, 1, 0), mk(0, 0, 0, 0, 0, 0, 0, 0, 0),
                 mk(0, 0, 0, 0, 0, 0, 0, 0, 0), mk(1, 1, 0, 0, 0, 0, 8, 1, 0)};
        run_prog(12);
        chk(stall_cnt[3] == 1, "port conflict add R6", stall_cnt[3], 1);

        // R3: branch waits on its tested register
        prog = '{mk(1, 0, 0, 0, 0, 0, 9, 1, 0), mk(1, 0, 9, 1, 0, 0, 0, 0, 1)};
        run_prog(6);
        chk(stall_cnt[1] == 2, "branch wait R3", stall_cnt[1], 2);

        // R7: register 0 and disabled destination
        prog = '{mk(1, 2, 0, 0, 0, 0, 0, 1, 0), mk(1, 0, 0, 1, 0, 1, 5, 1, 0),
                 mk(1, 2, 0, 0, 0, 0, 10, 0, 0), mk(1, 0, 10, 1, 0, 0, 11, 1, 0)};
        run_prog(12);
        chk(stall_cnt[1] == 0, "register 0 R7", stall_cnt[1], 0);
        chk(stall_cnt[3] == 0, "no destination R7", stall_cnt[3], 0);

        // R10: float work in flight, independent instructions flow
        prog = '{mk(1, 2, 0, 0, 0, 0, 12, 1, 0), mk(1, 1, 0, 0, 0, 0, 13, 1, 0),
                 mk(1, 0, 1, 1, 2, 1, 14, 1, 0), mk(1, 2, 0, 0, 0, 0, 15, 1, 0)};
        run_prog(12);
        chk(stall_cnt[1] + stall_cnt[2] + stall_cnt[3] == 0, "overlapped float R10",
            stall_cnt[1] + stall_cnt[2] + stall_cnt[3], 0);

        // R9: reset with a multiply in flight clears the record
        prog = '{mk(1, 2, 0, 0, 0, 0, 11, 1, 0)};
        run_prog(0);
        do_reset();
        prog = '{mk(1, 0, 11, 1, 0, 0, 0, 0, 0)};
        run_prog(4);
        chk(stall_cnt[0] == 0, "reset clears in-flight R9", stall_cnt[0], 0);

        // Mixed pseudo-random stream over registers 0..7
        prog.delete();
        for (int k = 0; k < 400; k++) begin
            bit br;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            br = (lfsr[2:0] == 3'd0);
            prog.push_back(mk(lfsr[15:14] != 2'd0, int'(lfsr[4:3]), int'(lfsr[7:5]), lfsr[8],
                              int'(lfsr[11:9]), lfsr[12], int'({lfsr[1:0], lfsr[13]}), !br, br));
        end
        run_prog(12);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule